// File: doc/BRIEF.md
# Split-ALU Pipeline Bypass and Interlock Controller

This block steers operands and freezes the front end of an in-order, six-stage pipeline: fetch, register read/decode, address ALU, memory, operation ALU, write-back. The instruction set is register-memory. The address ALU (stage three) adds a base register to an offset for every memory reference. The operation ALU (stage five) performs add, subtract, AND and OR. Its second operand is either a register or the word just read from memory.

Each cycle, the decode stage presents one decoded instruction tag: a valid bit, a kind, a destination and two source register numbers. The controller carries these tags down its own shadow of the pipeline. In the address-ALU, memory and operation-ALU stages, it tells the datapath whether to keep the operand it is carrying or to take a newer value. The newer value can come from the operation-ALU result or from the write-back latch. For the decode stage, it says when a register read must take the value being written in the same cycle.

Only one case cannot be covered by bypassing. That case is a memory reference whose base register is produced by the instruction just ahead of it. The controller then raises a stall that holds fetch and decode for one cycle and inserts a bubble into the address-ALU stage. The register file, the ALUs and the memory stay outside the block.

Top module: `pipe_bypass_ctl`

## Requirements
- R1: Kind codes are 0 register-register (rd = ra op rb), 1 register-memory (rd = ra op mem[rb+off]), 2 load (rd = mem[rb+off]) and 3 store (mem[rb+off] = ra). `stall` is 1 in a cycle only when the decode record is valid, its kind is 1, 2 or 3, and the address-ALU stage holds a valid kind 0, 1 or 2 writing that record's nonzero `rb`. While stalled, the record presented at decode is not taken in and a bubble enters the address-ALU stage, so a stall never lasts two cycles.
- R2: A producer one stage further ahead (in the memory stage when the consumer is at decode) causes no stall. The next cycle, the base operand in the address-ALU stage is bypassed from the operation-ALU output (`a1_sel_b` = 1).
- R3: Address-ALU stage selects use 0 = keep, 1 = operation-ALU output, 2 = write-back latch. When both stages write the needed register, code 1 wins.
- R4: Memory-stage selects use the same codes and priority. `mem_sel_a` refreshes the store data and the carried first operand of kinds 0 and 1.
- R5: In the operation-ALU stage, `a2_sel_a` and `a2_sel_b` of a kind-0 record are 2 when write-back writes the source and 0 otherwise. `a2_sel_b` is 3 (memory word) for kinds 1 and 2.
- R6: `rf_byp_a`/`rf_byp_b` are 1 when the write-back stage writes the nonzero register named by `rf_ra`/`rf_rb` of a valid decode record that reads it.
- R7: Register 0, an invalid record and a store never act as producers for any select or for the stall.
- R8: A load's `ra` field is ignored: `rf_byp_a`, and the A selects of a load in later stages, stay 0.
- R9: After the address-ALU stage, the base field of kinds 1, 2 and 3 is dead: `mem_sel_b` stays 0 for them.
- R10: After reset, all outputs are 0 until valid records enter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rf_valid | input | 1 | Decode-stage record is a real instruction |
| rf_kind | input | 2 | Decode-stage kind code |
| rf_rd | input | REG_W | Decode-stage destination register |
| rf_ra | input | REG_W | Decode-stage first source (data) register |
| rf_rb | input | REG_W | Decode-stage second source / base register |
| stall | output | 1 | Hold fetch and decode, bubble into address ALU |
| rf_byp_a | output | 1 | Decode read of `ra` takes write-back data |
| rf_byp_b | output | 1 | Decode read of `rb` takes write-back data |
| a1_sel_a | output | 2 | Address-ALU stage refresh of operand A |
| a1_sel_b | output | 2 | Address-ALU stage base / operand B select |
| mem_sel_a | output | 2 | Memory stage refresh of operand A / store data |
| mem_sel_b | output | 2 | Memory stage refresh of operand B |
| a2_sel_a | output | 2 | Operation-ALU operand A select |
| a2_sel_b | output | 2 | Operation-ALU operand B select |

## Verification
The properties take for granted that reset is held low for at least one rising edge and that `rf_kind` and the register fields are always defined values. They also assume the upstream logic re-presents the same decode record in the cycle after `stall`, since the block itself never takes that record. The directed stimulus changes inputs only on the falling edge and repeats the stalled record exactly once. Between scenarios it drains the shadow pipeline with four invalid records, so each scenario starts from empty stages and its expected selects follow from hand-counted stage positions.

// File: rtl/pbc_pkg.sv
package pbc_pkg;

   typedef enum logic [1:0] {
      K_RR = 2'd0,
      K_RM = 2'd1,
      K_LD = 2'd2,
      K_ST = 2'd3
   } kind_e;

   localparam logic [1:0] SEL_KEEP  = 2'd0;
   localparam logic [1:0] SEL_ALU2  = 2'd1;
   localparam logic [1:0] SEL_WB    = 2'd2;
   localparam logic [1:0] SEL_MWORD = 2'd3;

   // consumer stage indices inside the shadow pipeline
   localparam int CS_A1  = 0;
   localparam int CS_MEM = 1;
   localparam int CS_A2  = 2;
   localparam int N_CS   = 3;

   function automatic logic kind_writes(input logic [1:0] k);
      return k != K_ST;
   endfunction

   function automatic logic kind_reads_a(input logic [1:0] k);
      return k != K_LD;
   endfunction

   function automatic logic kind_has_base(input logic [1:0] k);
      return k != K_RR;
   endfunction

endpackage

// File: rtl/pbc_tag_pipe.sv
module pbc_tag_pipe
   import pbc_pkg::*;
#(
   parameter int REG_W = 5
)(
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         bubble,
   input  logic                         in_valid,
   input  logic [1:0]                   in_kind,
   input  logic [REG_W-1:0]             in_rd,
   input  logic [REG_W-1:0]             in_ra,
   input  logic [REG_W-1:0]             in_rb,
   output logic [N_CS-1:0]              c_valid,
   output logic [N_CS-1:0][1:0]         c_kind,
   output logic [N_CS-1:0][REG_W-1:0]   c_ra,
   output logic [N_CS-1:0][REG_W-1:0]   c_rb,
   output logic                         a1_wr,
   output logic [REG_W-1:0]             a1_rd,
   output logic                         a2_wr,
   output logic [REG_W-1:0]             a2_rd,
   output logic                         wb_wr,
   output logic [REG_W-1:0]             wb_rd
);

   logic [N_CS-1:0][REG_W-1:0] s_rd;

   for (genvar s = 0; s < N_CS; s++) begin : g_stage
      if (s == 0) begin : g_head
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               c_valid[s] <= 1'b0;
               c_kind[s]  <= '0;
               s_rd[s]    <= '0;
               c_ra[s]    <= '0;
               c_rb[s]    <= '0;
            end else begin
               c_valid[s] <= in_valid & ~bubble;
               c_kind[s]  <= in_kind;
               s_rd[s]    <= in_rd;
               c_ra[s]    <= in_ra;
               c_rb[s]    <= in_rb;
            end
         end
      end else begin : g_body
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               c_valid[s] <= 1'b0;
               c_kind[s]  <= '0;
               s_rd[s]    <= '0;
               c_ra[s]    <= '0;
               c_rb[s]    <= '0;
            end else begin
               c_valid[s] <= c_valid[s-1];
               c_kind[s]  <= c_kind[s-1];
               s_rd[s]    <= s_rd[s-1];
               c_ra[s]    <= c_ra[s-1];
               c_rb[s]    <= c_rb[s-1];
            end
         end
      end
   end

   // write-back keeps only what a producer needs
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wb_wr <= 1'b0;
         wb_rd <= '0;
      end else begin
         wb_wr <= c_valid[CS_A2] & kind_writes(c_kind[CS_A2]);
         wb_rd <= s_rd[CS_A2];
      end
   end

   assign a1_wr = c_valid[CS_A1] & kind_writes(c_kind[CS_A1]);
   assign a1_rd = s_rd[CS_A1];
   assign a2_wr = c_valid[CS_A2] & kind_writes(c_kind[CS_A2]);
   assign a2_rd = s_rd[CS_A2];

endmodule

// File: rtl/pbc_pick.sv
module pbc_pick
   import pbc_pkg::*;
#(
   parameter int                 REG_W = 5,
   parameter int                 NPROD = 2,
   parameter logic [2*NPROD-1:0] CODES = {SEL_WB, SEL_ALU2}
)(
   input  logic                          need,
   input  logic [REG_W-1:0]              src,
   input  logic [NPROD-1:0]              prod_wr,
   input  logic [NPROD-1:0][REG_W-1:0]   prod_rd,
   output logic [1:0]                    sel
);

   // index 0 is the youngest producer; scanning downward lets it win
   always_comb begin
      sel = SEL_KEEP;
      for (int i = NPROD - 1; i >= 0; i--) begin
         if (need && prod_wr[i] && (prod_rd[i] == src) && (src != '0))
            sel = CODES[2*i +: 2];
      end
   end

endmodule

// File: rtl/pbc_hazard.sv
module pbc_hazard
   import pbc_pkg::*;
#(
   parameter int REG_W = 5
)(
   input  logic             rf_valid,
   input  logic [1:0]       rf_kind,
   input  logic [REG_W-1:0] rf_rb,
   input  logic             a1_wr,
   input  logic [REG_W-1:0] a1_rd,
   output logic             stall
);

   logic base_live;

   assign base_live = rf_valid & kind_has_base(rf_kind) & (rf_rb != '0);
   assign stall     = base_live & a1_wr & (a1_rd == rf_rb);

endmodule

// File: rtl/pipe_bypass_ctl.sv
module pipe_bypass_ctl
   import pbc_pkg::*;
#(
   parameter int REG_W            = 5,
   parameter bit RF_WRITE_THROUGH = 1'b1
)(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             rf_valid,
   input  logic [1:0]       rf_kind,
   input  logic [REG_W-1:0] rf_rd,
   input  logic [REG_W-1:0] rf_ra,
   input  logic [REG_W-1:0] rf_rb,
   output logic             stall,
   output logic             rf_byp_a,
   output logic             rf_byp_b,
   output logic [1:0]       a1_sel_a,
   output logic [1:0]       a1_sel_b,
   output logic [1:0]       mem_sel_a,
   output logic [1:0]       mem_sel_b,
   output logic [1:0]       a2_sel_a,
   output logic [1:0]       a2_sel_b
);

   localparam int N_OP  = 2;
   localparam int N_MID = 2;

   if (REG_W < 2 || REG_W > 8) begin : g_bad_width
      $error("pipe_bypass_ctl: REG_W out of range");
   end

   logic [N_CS-1:0]            c_valid;
   logic [N_CS-1:0][1:0]       c_kind;
   logic [N_CS-1:0][REG_W-1:0] c_ra;
   logic [N_CS-1:0][REG_W-1:0] c_rb;
   logic                       a1_wr, a2_wr, wb_wr;
   logic [REG_W-1:0]           a1_rd, a2_rd, wb_rd;

   pbc_hazard #(.REG_W(REG_W)) u_haz (
      .rf_valid (rf_valid),
      .rf_kind  (rf_kind),
      .rf_rb    (rf_rb),
      .a1_wr    (a1_wr),
      .a1_rd    (a1_rd),
      .stall    (stall)
   );

   pbc_tag_pipe #(.REG_W(REG_W)) u_tags (
      .clk      (clk),
      .rst_n    (rst_n),
      .bubble   (stall),
      .in_valid (rf_valid),
      .in_kind  (rf_kind),
      .in_rd    (rf_rd),
      .in_ra    (rf_ra),
      .in_rb    (rf_rb),
      .c_valid  (c_valid),
      .c_kind   (c_kind),
      .c_ra     (c_ra),
      .c_rb     (c_rb),
      .a1_wr    (a1_wr),
      .a1_rd    (a1_rd),
      .a2_wr    (a2_wr),
      .a2_rd    (a2_rd),
      .wb_wr    (wb_wr),
      .wb_rd    (wb_rd)
   );

   // address-ALU and memory stages: producers are operation ALU then write-back
   logic [1:0] mid_sel [N_MID][N_OP];

   for (genvar st = 0; st < N_MID; st++) begin : g_mid
      for (genvar op = 0; op < N_OP; op++) begin : g_op
         logic need;
         if (op == 0) begin : g_a
            assign need = c_valid[st] & kind_reads_a(c_kind[st]);
         end else if (st == CS_A1) begin : g_base
            assign need = c_valid[st];
         end else begin : g_late_b
            assign need = c_valid[st] & (c_kind[st] == K_RR);
         end
         pbc_pick #(.REG_W(REG_W), .NPROD(2), .CODES({SEL_WB, SEL_ALU2})) u_pick (
            .need    (need),
            .src     (op == 0 ? c_ra[st] : c_rb[st]),
            .prod_wr ({wb_wr, a2_wr}),
            .prod_rd ({wb_rd, a2_rd}),
            .sel     (mid_sel[st][op])
         );
      end
   end

   assign a1_sel_a  = mid_sel[CS_A1][0];
   assign a1_sel_b  = mid_sel[CS_A1][1];
   assign mem_sel_a = mid_sel[CS_MEM][0];
   assign mem_sel_b = mid_sel[CS_MEM][1];

   // operation-ALU stage: only write-back is older
   logic [1:0] a2_pick [N_OP];
   logic       a2_is_rr, a2_mem_op;

   assign a2_is_rr  = c_valid[CS_A2] & (c_kind[CS_A2] == K_RR);
   assign a2_mem_op = c_valid[CS_A2] & ((c_kind[CS_A2] == K_RM) | (c_kind[CS_A2] == K_LD));

   for (genvar op = 0; op < N_OP; op++) begin : g_a2
      logic need;
      if (op == 0) begin : g_a
         assign need = a2_is_rr | (c_valid[CS_A2] & (c_kind[CS_A2] == K_RM));
      end else begin : g_b
         assign need = a2_is_rr;
      end
      pbc_pick #(.REG_W(REG_W), .NPROD(1), .CODES(SEL_WB)) u_pick (
         .need    (need),
         .src     (op == 0 ? c_ra[CS_A2] : c_rb[CS_A2]),
         .prod_wr (wb_wr),
         .prod_rd (wb_rd),
         .sel     (a2_pick[op])
      );
   end

   assign a2_sel_a = a2_pick[0];
   assign a2_sel_b = a2_mem_op ? SEL_MWORD : a2_pick[1];

   // decode-stage read bypass from the write-back latch
   if (RF_WRITE_THROUGH) begin : g_rf_byp
      logic [1:0] rf_pick [N_OP];
      for (genvar op = 0; op < N_OP; op++) begin : g_op
         logic need;
         if (op == 0) begin : g_a
            assign need = rf_valid & kind_reads_a(rf_kind);
         end else begin : g_b
            assign need = rf_valid;
         end
         pbc_pick #(.REG_W(REG_W), .NPROD(1), .CODES(SEL_WB)) u_pick (
            .need    (need),
            .src     (op == 0 ? rf_ra : rf_rb),
            .prod_wr (wb_wr),
            .prod_rd (wb_rd),
            .sel     (rf_pick[op])
         );
      end
      assign rf_byp_a = rf_pick[0] != SEL_KEEP;
      assign rf_byp_b = rf_pick[1] != SEL_KEEP;
   end else begin : g_no_rf_byp
      // register file resolves same-cycle write/read internally
      assign rf_byp_a = 1'b0;
      assign rf_byp_b = 1'b0;
   end

endmodule

// File: rtl/pbc_checker.sv
module pbc_checker
   import pbc_pkg::*;
#(
   parameter int REG_W = 5
)(
   input logic             clk,
   input logic             rst_n,
   input logic             rf_valid,
   input logic [1:0]       rf_kind,
   input logic [REG_W-1:0] rf_rb,
   input logic             stall,
   input logic             rf_byp_a,
   input logic [1:0]       a1_sel_a,
   input logic [1:0]       a1_sel_b,
   input logic [1:0]       mem_sel_a,
   input logic [1:0]       mem_sel_b,
   input logic [1:0]       a2_sel_a
);

   assert_stall_once_R1: assert property (@(posedge clk) disable iff (!rst_n)
      stall |=> !stall);

   assert_bubble_after_stall_R1: assert property (@(posedge clk) disable iff (!rst_n)
      stall |=> (a1_sel_a == SEL_KEEP && a1_sel_b == SEL_KEEP));

   assert_rr_never_stalls_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (rf_kind == K_RR) |-> !stall);

   assert_r0_no_stall_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (rf_rb == '0) |-> !stall);

   assert_a1_code_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (a1_sel_a != SEL_MWORD) && (a1_sel_b != SEL_MWORD));

   assert_mem_code_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_sel_a != SEL_MWORD) && (mem_sel_b != SEL_MWORD));

   assert_a2a_code_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (a2_sel_a == SEL_KEEP) || (a2_sel_a == SEL_WB));

   assert_load_ignores_a_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (rf_valid && rf_kind == K_LD) |-> !rf_byp_a);

endmodule

bind pipe_bypass_ctl pbc_checker #(.REG_W(REG_W)) u_pbc_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .rf_valid  (rf_valid),
   .rf_kind   (rf_kind),
   .rf_rb     (rf_rb),
   .stall     (stall),
   .rf_byp_a  (rf_byp_a),
   .a1_sel_a  (a1_sel_a),
   .a1_sel_b  (a1_sel_b),
   .mem_sel_a (mem_sel_a),
   .mem_sel_b (mem_sel_b),
   .a2_sel_a  (a2_sel_a)
);

// File: tb/sim_pipe_bypass_ctl.sv
module sim_pipe_bypass_ctl;

   localparam int REG_W = 5;
   localparam logic [1:0] KRR = 2'd0, KRM = 2'd1, KLD = 2'd2, KST = 2'd3;

   logic clk = 1'b0;
   logic rst_n;
   logic rf_valid;
   logic [1:0] rf_kind;
   logic [REG_W-1:0] rf_rd, rf_ra, rf_rb;
   logic stall, rf_byp_a, rf_byp_b;
   logic [1:0] a1_sel_a, a1_sel_b, mem_sel_a, mem_sel_b, a2_sel_a, a2_sel_b;

   int n_chk = 0;
   int n_bad = 0;

   always #4 clk = ~clk;

   pipe_bypass_ctl #(.REG_W(REG_W)) u0 (
      .clk(clk), .rst_n(rst_n), .rf_valid(rf_valid), .rf_kind(rf_kind),
      .rf_rd(rf_rd), .rf_ra(rf_ra), .rf_rb(rf_rb), .stall(stall),
      .rf_byp_a(rf_byp_a), .rf_byp_b(rf_byp_b), .a1_sel_a(a1_sel_a),
      .a1_sel_b(a1_sel_b), .mem_sel_a(mem_sel_a), .mem_sel_b(mem_sel_b),
      .a2_sel_a(a2_sel_a), .a2_sel_b(a2_sel_b));

   task automatic chk(input string req, input string what, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   // present a decode record on the falling edge, sample 2 ns before the rising edge
   task automatic issue(input logic v, input logic [1:0] k, input int rd, input int ra, input int rb);
      @(negedge clk);
      rf_valid = v;
      rf_kind  = k;
      rf_rd    = REG_W'(rd);
      rf_ra    = REG_W'(ra);
      rf_rb    = REG_W'(rb);
      #2;
   endtask

   task automatic nop();
      issue(1'b0, KRR, 0, 0, 0);
   endtask

   task automatic drain();
      for (int i = 0; i < 4; i++) nop();
   endtask

   task automatic t_reset();
      rst_n = 1'b0;
      rf_valid = 1'b0; rf_kind = KRR; rf_rd = '0; rf_ra = '0; rf_rb = '0;
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      nop();
      chk("R10", "stall", stall, 0);
      chk("R10", "rf bypass", {rf_byp_a, rf_byp_b}, 0);
      chk("R10", "mid selects", {a1_sel_a, a1_sel_b, mem_sel_a, mem_sel_b}, 0);
      chk("R10", "alu2 selects", {a2_sel_a, a2_sel_b}, 0);
   endtask

   task automatic t_load_base_adjacent();
      drain();
      issue(1, KLD, 3, 0, 2);
      chk("R1", "no stall on first load", stall, 0);
      issue(1, KRM, 4, 5, 3);
      chk("R1", "stall on adjacent base", stall, 1);
      issue(1, KRM, 4, 5, 3);
      chk("R1", "stall released", stall, 0);
      nop();
      chk("R2", "a1_sel_b from alu2", a1_sel_b, 1);
      chk("R3", "a1_sel_a unrelated", a1_sel_a, 0);
      nop();
      chk("R9", "dead base in mem", mem_sel_b, 0);
      nop();
      chk("R5", "reg-mem takes word", a2_sel_b, 3);
   endtask

   task automatic t_alu_base_adjacent();
      drain();
      issue(1, KRR, 25, 1, 1);
      issue(1, KST, 0, 2, 25);
      chk("R1", "alu producer stalls store", stall, 1);
      issue(1, KST, 0, 2, 25);
      chk("R1", "held store released", stall, 0);
      drain();
      issue(1, KRR, 23, 1, 1);
      issue(1, KRR, 24, 23, 23);
      chk("R1", "reg-reg consumer never stalls", stall, 0);
   endtask

   task automatic t_base_distance2();
      drain();
      issue(1, KRR, 6, 1, 2);
      issue(1, KRR, 7, 1, 1);
      issue(1, KST, 0, 9, 6);
      chk("R2", "no stall at distance 2", stall, 0);
      nop();
      chk("R2", "base from alu2", a1_sel_b, 1);
      chk("R3", "unrelated store data", a1_sel_a, 0);
   endtask

   task automatic t_base_distance3();
      drain();
      issue(1, KRR, 8, 1, 1);
      nop();
      nop();
      issue(1, KLD, 9, 0, 8);
      chk("R1", "no stall at distance 3", stall, 0);
      nop();
      chk("R3", "base from write-back", a1_sel_b, 2);
      nop();
      nop();
      chk("R5", "load takes word", a2_sel_b, 3);
      chk("R8", "load A unused in alu2", a2_sel_a, 0);
   endtask

   task automatic t_priority();
      drain();
      issue(1, KRR, 12, 1, 1);
      issue(1, KRR, 12, 2, 2);
      issue(1, KRR, 11, 12, 12);
      nop();
      chk("R3", "a1 A alu2 wins", a1_sel_a, 1);
      chk("R3", "a1 B alu2 wins", a1_sel_b, 1);
      nop();
      chk("R4", "mem A youngest wins", mem_sel_a, 1);
      chk("R4", "mem B youngest wins", mem_sel_b, 1);
      nop();
      chk("R5", "alu2 A from wb", a2_sel_a, 2);
      chk("R5", "alu2 B from wb", a2_sel_b, 2);
   endtask

   task automatic t_store_data();
      drain();
      issue(1, KRR, 13, 1, 1);
      issue(1, KST, 0, 13, 2);
      chk("R1", "no base clash", stall, 0);
      nop();
      chk("R3", "data not ready in a1", a1_sel_a, 0);
      nop();
      chk("R4", "store data from alu2", mem_sel_a, 1);
      drain();
      issue(1, KRR, 14, 1, 1);
      nop();
      issue(1, KST, 0, 14, 3);
      nop();
      chk("R3", "store data refresh in a1", a1_sel_a, 1);
      nop();
      chk("R4", "store data from wb", mem_sel_a, 2);
   endtask

   task automatic t_rf_bypass();
      drain();
      issue(1, KRR, 5, 1, 1);
      nop(); nop(); nop();
      issue(1, KRR, 15, 5, 5);
      chk("R6", "rf A write-through", rf_byp_a, 1);
      chk("R6", "rf B write-through", rf_byp_b, 1);
      drain();
      issue(1, KRR, 5, 1, 1);
      nop(); nop(); nop();
      issue(1, KLD, 16, 5, 5);
      chk("R8", "load ra ignored", rf_byp_a, 0);
      chk("R6", "load base write-through", rf_byp_b, 1);
   endtask

   task automatic t_non_producers();
      drain();
      issue(1, KLD, 0, 1, 1);
      issue(1, KLD, 17, 1, 0);
      chk("R7", "r0 never stalls", stall, 0);
      drain();
      issue(1, KST, 18, 1, 1);
      issue(1, KLD, 19, 1, 18);
      chk("R7", "store never stalls", stall, 0);
      drain();
      issue(0, KLD, 22, 1, 1);
      issue(1, KLD, 21, 1, 22);
      chk("R7", "invalid never stalls", stall, 0);
      drain();
      issue(0, KRR, 20, 1, 1);
      issue(1, KRR, 21, 20, 20);
      nop();
      nop();
      chk("R7", "invalid never forwards", {mem_sel_a, mem_sel_b}, 0);
      drain();
      issue(1, KRR, 0, 1, 1);
      nop();
      issue(1, KRR, 26, 0, 0);
      nop();
      chk("R7", "r0 never forwards", {a1_sel_a, a1_sel_b}, 0);
   endtask

   initial begin
      t_reset();
      t_load_base_adjacent();
      t_alu_base_adjacent();
      t_base_distance2();
      t_base_distance3();
      t_priority();
      t_store_data();
      t_rf_bypass();
      t_non_producers();
      drain();
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

endmodule